// File: doc/BRIEF.md
# Partitioned SIMD Integer Execution Unit

This block is a pipelined 256-bit integer and logic execution unit whose datapath is cut at run time into independent elements of 16, 32 or 64 bits, chosen for each operation. One shared segmented adder serves add, subtract and signed compare. Shift and multiply results are formed per element, and a merge stage applies a per-element predicate. A full-width operation therefore completes sixteen 16-bit, eight 32-bit or four 64-bit element operations at once.

An operation is issued by asserting `in_valid` together with the opcode, the width code, both operands, the current destination contents and the predicate mask. Exactly three clock edges later, counting the edge that accepts the operation, the result appears with `out_valid`. A new operation may be issued on every cycle. Elements whose predicate bit is clear keep the destination value supplied with the operation. An 8-bit width request, or an undefined opcode, is rejected and writes nothing.

Top module: `simd_alu`

## Requirements
- R1: Opcode 0 (add) and opcode 1 (subtract) operate on each element independently and wrap modulo 2^width. No carry or borrow ever passes from one element into the next.
- R2: Opcodes 2, 3 and 4 return the bitwise AND, OR and XOR of the operands.
- R3: Opcode 5 (logical left shift) and opcode 6 (logical right shift) shift each element of A by the low log2(width) bits of the same element of B. The shifts fill with zeros, and bits shifted out of an element never enter a neighbouring element.
- R4: Opcode 7 compares each element of A against the same element of B as signed integers. If A is less than B, the element becomes all ones and flag bit e is set; otherwise the element becomes all zeros and the flag bit is clear. This holds when the subtraction overflows.
- R5: Opcode 8 returns the low width bits of the product of each pair of elements.
- R6: Element e takes its result only when predicate bit e is set, and `out_wmask` bit e reports this. A masked-off element returns its `in_prev` bits unchanged and has a clear flag.
- R7: Width code 0 (8-bit) or any opcode from 9 to 15 is rejected. `out_illegal` is set, `out_wmask` and `out_flags` are zero, and `out_result` equals `in_prev`.
- R8: An operation accepted at a rising edge appears at the outputs after the third rising edge counting that one. Operations may be issued every cycle, and a cycle without `in_valid` gives a cycle with `out_valid` low and `out_wmask` zero.
- R9: A synchronous active-high reset clears `out_valid`, `out_wmask`, `out_flags` and `out_illegal`, and drops every operation still in the pipeline.
- R10: Width codes 1, 2 and 3 select 16, 32 and 64-bit elements. Element e occupies bits [e*width +: width], and bit e of the predicate, `out_wmask` and `out_flags` refers to element e. `out_wmask` and `out_flags` bits at or above the element count (16, 8 or 4) are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation issue strobe |
| in_op | input | 4 | Opcode (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 sll, 6 srl, 7 signed less-than, 8 multiply low) |
| in_width | input | 2 | Element width code (0 8-bit illegal, 1 16-bit, 2 32-bit, 3 64-bit) |
| in_a | input | 256 | Operand A |
| in_b | input | 256 | Operand B, also the shift amounts |
| in_prev | input | 256 | Present destination contents |
| in_pred | input | 16 | Per-element predicate |
| out_valid | output | 1 | Result strobe |
| out_result | output | 256 | Merged result |
| out_wmask | output | 16 | Elements written |
| out_flags | output | 16 | Per-element compare flags |
| out_illegal | output | 1 | Operation rejected |

## Verification
Predicate gating and compare-flag generation act on the same element in the same cycle. The merge stage must let a set predicate pass both the all-ones element and its flag, and a clear predicate must suppress both. The bench runs the signed compare at every width with full, empty and random masks. It includes operand pairs whose difference overflows and operand pairs that are equal. Each result element is compared against either the computed compare value or the supplied previous contents. Each flag is compared against the compare outcome ANDed with its predicate bit.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam logic [3:0] OPC_ADD = 4'd0;
  localparam logic [3:0] OPC_SUB = 4'd1;
  localparam logic [3:0] OPC_AND = 4'd2;
  localparam logic [3:0] OPC_OR  = 4'd3;
  localparam logic [3:0] OPC_XOR = 4'd4;
  localparam logic [3:0] OPC_SLL = 4'd5;
  localparam logic [3:0] OPC_SRL = 4'd6;
  localparam logic [3:0] OPC_SLT = 4'd7;
  localparam logic [3:0] OPC_MUL = 4'd8;
  localparam logic [3:0] OPC_LAST = OPC_MUL;

  localparam logic [1:0] EW_8  = 2'd0;
  localparam logic [1:0] EW_16 = 2'd1;
  localparam logic [1:0] EW_32 = 2'd2;
  localparam logic [1:0] EW_64 = 2'd3;

  typedef struct packed {
    logic       ill;
    logic [3:0] op;
    logic [1:0] w;
  } simd_ctl_t;
endpackage

// File: rtl/simd_addsub.sv
module simd_addsub #(
  parameter int DATA_W  = 256,
  parameter int SLICE_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic [1:0]        wsel,
  output logic [DATA_W-1:0] sum
);
  import simd_pkg::*;
  localparam int NS = DATA_W / SLICE_W;

  logic [NS-1:0] ci;
  logic [NS-2:0] co;

  for (genvar s = 0; s < NS; s++) begin : g_slice
    localparam bit ON2 = (s % 2) == 0;
    localparam bit ON4 = (s % 4) == 0;
    logic [SLICE_W-1:0] bx;
    assign bx = sub ? ~b[s*SLICE_W +: SLICE_W] : b[s*SLICE_W +: SLICE_W];

    if (s == 0) begin : g_first
      assign ci[s] = sub;
    end else begin : g_rest
      logic cut;
      assign cut = (wsel == EW_8) || (wsel == EW_16) ||
                   ((wsel == EW_32) && ON2) || ((wsel == EW_64) && ON4);
      assign ci[s] = cut ? sub : co[s-1];
    end

    if (s < NS - 1) begin : g_carry
      logic [SLICE_W:0] tot;
      assign tot = {1'b0, a[s*SLICE_W +: SLICE_W]} + {1'b0, bx} +
                   {{SLICE_W{1'b0}}, ci[s]};
      assign sum[s*SLICE_W +: SLICE_W] = tot[SLICE_W-1:0];
      assign co[s] = tot[SLICE_W];
    end else begin : g_top
      assign sum[s*SLICE_W +: SLICE_W] = a[s*SLICE_W +: SLICE_W] + bx +
                                         {{(SLICE_W-1){1'b0}}, ci[s]};
    end
  end
endmodule

// File: rtl/simd_cmp.sv
module simd_cmp #(
  parameter int NS = 16
) (
  input  logic [NS-1:0] a_msb,
  input  logic [NS-1:0] b_msb,
  input  logic [NS-1:0] d_msb,
  input  logic [1:0]    wsel,
  output logic [NS-1:0] lt_sl
);
  import simd_pkg::*;

  // signed less-than from the sign bits and the difference sign
  logic [NS-1:0] lt_top;
  for (genvar t = 0; t < NS; t++) begin : g_top
    assign lt_top[t] = (a_msb[t] ^ b_msb[t]) ? a_msb[t] : d_msb[t];
  end

  for (genvar s = 0; s < NS; s++) begin : g_slice
    localparam int T2 = s | 1;
    localparam int T4 = s | 3;
    always_comb begin
      unique case (wsel)
        EW_32:   lt_sl[s] = lt_top[T2];
        EW_64:   lt_sl[s] = lt_top[T4];
        default: lt_sl[s] = lt_top[s];
      endcase
    end
  end
endmodule

// File: rtl/simd_shift.sv
module simd_shift #(
  parameter int DATA_W  = 256,
  parameter int SLICE_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        wsel,
  input  logic              right,
  output logic [DATA_W-1:0] res
);
  import simd_pkg::*;
  localparam int NW = 3;

  logic [NW*DATA_W-1:0] sll_all, srl_all;
  logic unused_b;
  assign unused_b = ^b;

  for (genvar k = 0; k < NW; k++) begin : g_width
    localparam int EW = SLICE_W << k;
    localparam int NE = DATA_W / EW;
    localparam int AW = $clog2(EW);
    for (genvar e = 0; e < NE; e++) begin : g_elem
      logic [AW-1:0] amt;
      assign amt = b[e*EW +: AW];
      assign sll_all[k*DATA_W + e*EW +: EW] = a[e*EW +: EW] << amt;
      assign srl_all[k*DATA_W + e*EW +: EW] = a[e*EW +: EW] >> amt;
    end
  end

  logic [1:0] sel;
  assign sel = (wsel == EW_64) ? 2'd2 : (wsel == EW_32) ? 2'd1 : 2'd0;
  assign res = right ? srl_all[sel*DATA_W +: DATA_W] : sll_all[sel*DATA_W +: DATA_W];
endmodule

// File: rtl/simd_mul.sv
module simd_mul #(
  parameter int DATA_W  = 256,
  parameter int SLICE_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        wsel,
  output logic [DATA_W-1:0] res
);
  import simd_pkg::*;
  localparam int NW = 3;

  logic [NW*DATA_W-1:0] prod_all;

  for (genvar k = 0; k < NW; k++) begin : g_width
    localparam int EW = SLICE_W << k;
    localparam int NE = DATA_W / EW;
    for (genvar e = 0; e < NE; e++) begin : g_elem
      assign prod_all[k*DATA_W + e*EW +: EW] = a[e*EW +: EW] * b[e*EW +: EW];
    end
  end

  logic [1:0] sel;
  assign sel = (wsel == EW_64) ? 2'd2 : (wsel == EW_32) ? 2'd1 : 2'd0;
  assign res = prod_all[sel*DATA_W +: DATA_W];
endmodule

// File: rtl/simd_alu.sv
module simd_alu #(
  parameter int DATA_W  = 256,
  parameter int SLICE_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [3:0]                   in_op,
  input  logic [1:0]                   in_width,
  input  logic [DATA_W-1:0]            in_a,
  input  logic [DATA_W-1:0]            in_b,
  input  logic [DATA_W-1:0]            in_prev,
  input  logic [DATA_W/SLICE_W-1:0]    in_pred,
  output logic                         out_valid,
  output logic [DATA_W-1:0]            out_result,
  output logic [DATA_W/SLICE_W-1:0]    out_wmask,
  output logic [DATA_W/SLICE_W-1:0]    out_flags,
  output logic                         out_illegal
);
  import simd_pkg::*;
  localparam int NS = DATA_W / SLICE_W;

  // ---------------- stage 1: capture ----------------
  logic              v1;
  simd_ctl_t         c1;
  logic [DATA_W-1:0] a1, b1, d1;
  logic [NS-1:0]     m1;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
  end

  always_ff @(posedge clk) begin
    c1.op  <= in_op;
    c1.w   <= in_width;
    c1.ill <= (in_width == EW_8) || (in_op > OPC_LAST);
    a1 <= in_a;
    b1 <= in_b;
    d1 <= in_prev;
    m1 <= in_pred;
  end

  // ---------------- stage 2: compute ----------------
  logic [DATA_W-1:0] sum_c, sh_c, mul_c, slt_c;
  logic [NS-1:0]     lt_c, a_msb, b_msb, s_msb;
  logic              use_sub;

  assign use_sub = (c1.op == OPC_SUB) || (c1.op == OPC_SLT);

  simd_addsub #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_addsub (
    .a(a1), .b(b1), .sub(use_sub), .wsel(c1.w), .sum(sum_c)
  );

  for (genvar s = 0; s < NS; s++) begin : g_msb
    assign a_msb[s] = a1[s*SLICE_W + SLICE_W - 1];
    assign b_msb[s] = b1[s*SLICE_W + SLICE_W - 1];
    assign s_msb[s] = sum_c[s*SLICE_W + SLICE_W - 1];
    assign slt_c[s*SLICE_W +: SLICE_W] = {SLICE_W{lt_c[s]}};
  end

  simd_cmp #(.NS(NS)) u_cmp (
    .a_msb(a_msb), .b_msb(b_msb), .d_msb(s_msb), .wsel(c1.w), .lt_sl(lt_c)
  );

  simd_shift #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_shift (
    .a(a1), .b(b1), .wsel(c1.w), .right(c1.op == OPC_SRL), .res(sh_c)
  );

  simd_mul #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_mul (
    .a(a1), .b(b1), .wsel(c1.w), .res(mul_c)
  );

  logic [DATA_W-1:0] res_c;
  always_comb begin
    unique case (c1.op)
      OPC_ADD, OPC_SUB: res_c = sum_c;
      OPC_AND:          res_c = a1 & b1;
      OPC_OR:           res_c = a1 | b1;
      OPC_XOR:          res_c = a1 ^ b1;
      OPC_SLL, OPC_SRL: res_c = sh_c;
      OPC_SLT:          res_c = slt_c;
      OPC_MUL:          res_c = mul_c;
      default:          res_c = '0;
    endcase
  end

  logic              v2;
  simd_ctl_t         c2;
  logic [DATA_W-1:0] r2, d2;
  logic [NS-1:0]     m2, lt2;

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v1;
  end

  always_ff @(posedge clk) begin
    c2  <= c1;
    r2  <= res_c;
    d2  <= d1;
    m2  <= m1;
    lt2 <= lt_c;
  end

  // ---------------- stage 3: predicate merge ----------------
  logic              live2;
  logic [DATA_W-1:0] merged;
  logic [NS-1:0]     wm_c, fl_c;

  assign live2 = v2 && !c2.ill;

  for (genvar s = 0; s < NS; s++) begin : g_merge
    logic en;
    always_comb begin
      unique case (c2.w)
        EW_32:   en = m2[s >> 1];
        EW_64:   en = m2[s >> 2];
        default: en = m2[s];
      endcase
    end
    assign merged[s*SLICE_W +: SLICE_W] = (live2 && en) ? r2[s*SLICE_W +: SLICE_W]
                                                        : d2[s*SLICE_W +: SLICE_W];
  end

  for (genvar e = 0; e < NS; e++) begin : g_elem
    localparam bit IN32 = e < NS / 2;
    localparam bit IN64 = e < NS / 4;
    logic in_rng, f32, f64, fsel;
    if (IN32) begin : g_f32
      assign f32 = lt2[e*2];
    end else begin : g_n32
      assign f32 = 1'b0;
    end
    if (IN64) begin : g_f64
      assign f64 = lt2[e*4];
    end else begin : g_n64
      assign f64 = 1'b0;
    end
    always_comb begin
      unique case (c2.w)
        EW_32:   begin in_rng = IN32; fsel = f32; end
        EW_64:   begin in_rng = IN64; fsel = f64; end
        default: begin in_rng = 1'b1; fsel = lt2[e]; end
      endcase
    end
    assign wm_c[e] = live2 && m2[e] && in_rng;
    assign fl_c[e] = wm_c[e] && fsel && (c2.op == OPC_SLT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_wmask   <= '0;
      out_flags   <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= v2;
      out_wmask   <= wm_c;
      out_flags   <= fl_c;
      out_illegal <= v2 && c2.ill;
    end
  end

  always_ff @(posedge clk) begin
    out_result <= merged;
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DATA_W = 256,
  parameter int NSLICE = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        in_width,
  input logic [DATA_W-1:0] in_prev,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic [NSLICE-1:0] out_wmask,
  input logic [NSLICE-1:0] out_flags,
  input logic              out_illegal
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                   since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_bubble_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_wmask == '0 && out_flags == '0 && !out_illegal));

  assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_valid && out_wmask == '0 && out_flags == '0));

  assert_reject_keeps_prev_R7: assert property (@(posedge clk) disable iff (rst)
    (out_illegal && since_rst == 2'd3) |-> (out_result == $past(in_prev, 3)));

  assert_flag_needs_write_R4: assert property (@(posedge clk) disable iff (rst)
    (out_flags & ~out_wmask) == '0);

  assert_wide_mask_range_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && since_rst == 2'd3 && $past(in_width, 3) == 2'd3)
      |-> ((out_wmask >> (NSLICE / 4)) == '0));

  assert_reset_clears_R9: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_wmask == '0 && !out_illegal));
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W), .NSLICE(DATA_W / SLICE_W)) u_simd_alu_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_width(in_width), .in_prev(in_prev),
  .out_valid(out_valid), .out_result(out_result), .out_wmask(out_wmask),
  .out_flags(out_flags), .out_illegal(out_illegal)
);

// File: tb/test_simd_alu.sv
`timescale 1ns/1ps
module test_simd_alu;
  localparam int DW = 256;
  localparam int SW = 16;
  localparam int NS = DW / SW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [3:0]    in_op = '0;
  logic [1:0]    in_width = '0;
  logic [DW-1:0] in_a = '0, in_b = '0, in_prev = '0;
  logic [NS-1:0] in_pred = '0;
  logic          out_valid;
  logic [DW-1:0] out_result;
  logic [NS-1:0] out_wmask, out_flags;
  logic          out_illegal;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  logic          q_v[$];
  logic [DW-1:0] q_d[$];
  logic [NS-1:0] q_wm[$], q_fl[$];
  logic          q_ill[$];
  string         q_tag[$];

  simd_alu #(.DATA_W(DW), .SLICE_W(SW)) i_simd_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_width(in_width),
    .in_a(in_a), .in_b(in_b), .in_prev(in_prev), .in_pred(in_pred),
    .out_valid(out_valid), .out_result(out_result), .out_wmask(out_wmask),
    .out_flags(out_flags), .out_illegal(out_illegal)
  );

  always #2.5 clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog: cycles=%0d expected below %0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  function automatic logic [DW-1:0] rnd();
    logic [DW-1:0] r;
    for (int i = 0; i < DW / 32; i++) r[i*32 +: 32] = $urandom();
    return r;
  endfunction

  function automatic logic [DW-1:0] rep(input int w, input logic [63:0] val);
    int ew;
    logic [63:0] mk;
    logic [DW-1:0] r;
    ew = SW << (w - 1);
    mk = ~64'd0 >> (64 - ew);
    r = '0;
    for (int e = 0; e < DW / ew; e++) r |= {192'd0, val & mk} << (e * ew);
    return r;
  endfunction

  // independent per-element reference
  task automatic model(input int op, input int w, input logic [DW-1:0] a, b, d,
                       input logic [NS-1:0] m, output logic [DW-1:0] r,
                       output logic [NS-1:0] wm, output logic [NS-1:0] fl,
                       output logic ill);
    int ew, ne, amt;
    logic [63:0] mk, sb, ea, eb, x;
    logic [DW-1:0] sh;
    bit lt;
    r = d; wm = '0; fl = '0; ill = 1'b0;
    if (w == 0 || op > 8) begin
      ill = 1'b1;
      return;
    end
    ew = SW << (w - 1);
    ne = DW / ew;
    mk = ~64'd0 >> (64 - ew);
    sb = 64'd1 << (ew - 1);
    for (int e = 0; e < ne; e++) begin
      sh = a >> (e * ew); ea = sh[63:0] & mk;
      sh = b >> (e * ew); eb = sh[63:0] & mk;
      amt = int'(eb & 64'(ew - 1));
      lt = ((ea ^ sb) < (eb ^ sb));
      case (op)
        0: x = ea + eb;
        1: x = ea - eb;
        2: x = ea & eb;
        3: x = ea | eb;
        4: x = ea ^ eb;
        5: x = ea << amt;
        6: x = ea >> amt;
        7: x = lt ? mk : 64'd0;
        default: x = ea * eb;
      endcase
      if (m[e]) begin
        r = (r & ~({192'd0, mk} << (e * ew))) | ({192'd0, x & mk} << (e * ew));
        wm[e] = 1'b1;
        fl[e] = (op == 7) && lt;
      end
    end
  endtask

  function automatic string tag_of(input int op, input int w);
    if (w == 0 || op > 8) return "R7";
    case (op)
      0, 1:    return "R1 R6 R10";
      2, 3, 4: return "R2 R6 R10";
      5, 6:    return "R3 R6 R10";
      7:       return "R4 R6 R10";
      default: return "R5 R6 R10";
    endcase
  endfunction

  task automatic step(input bit v, input int op, input int w,
                      input logic [DW-1:0] a, b, d, input logic [NS-1:0] m);
    logic [DW-1:0] er;
    logic [NS-1:0] ewm, efl;
    logic eill;
    @(negedge clk);
    if (q_v.size() == 3) begin
      logic ev, xi; logic [DW-1:0] xd; logic [NS-1:0] xw, xf; string t; bit ok;
      ev = q_v.pop_front(); xd = q_d.pop_front(); xw = q_wm.pop_front();
      xf = q_fl.pop_front(); xi = q_ill.pop_front(); t = q_tag.pop_front();
      checks++;
      if (!ev) ok = (out_valid === 1'b0) && (out_wmask === '0);
      else ok = (out_valid === 1'b1) && (out_result === xd) && (out_wmask === xw) &&
                (out_flags === xf) && (out_illegal === xi);
      if (!ok) begin
        failures++;
        $display("FAIL %s: got v=%0b res=%h wm=%h fl=%h ill=%0b exp v=%0b res=%h wm=%h fl=%h ill=%0b",
                 t, out_valid, out_result, out_wmask, out_flags, out_illegal,
                 ev, xd, xw, xf, xi);
      end
    end
    in_valid = v; in_op = 4'(op); in_width = 2'(w);
    in_a = a; in_b = b; in_prev = d; in_pred = m;
    if (v) begin
      model(op, w, a, b, d, m, er, ewm, efl, eill);
      q_tag.push_back(tag_of(op, w));
    end else begin
      er = '0; ewm = '0; efl = '0; eill = 1'b0;
      q_tag.push_back("R8 bubble");
    end
    q_v.push_back(v); q_d.push_back(er); q_wm.push_back(ewm);
    q_fl.push_back(efl); q_ill.push_back(eill);
  endtask

  task automatic check_clear(input string t);
    checks++;
    if (out_valid !== 1'b0 || out_wmask !== '0 || out_flags !== '0 || out_illegal !== 1'b0) begin
      failures++;
      $display("FAIL %s: got v=%0b wm=%h fl=%h ill=%0b exp all zero",
               t, out_valid, out_wmask, out_flags, out_illegal);
    end
  endtask

  task automatic flush_queues();
    q_v.delete(); q_d.delete(); q_wm.delete(); q_fl.delete(); q_ill.delete(); q_tag.delete();
  endtask

  initial begin
    // R9: state under reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_clear("R9 reset state");
    rst = 1'b0;

    // sweep every width, opcode and pattern, issued back to back (R8)
    for (int w = 1; w <= 3; w++) begin
      for (int op = 0; op <= 8; op++) begin
        for (int p = 0; p < 9; p++) begin
          logic [DW-1:0] a, b;
          logic [NS-1:0] m;
          int ew;
          ew = SW << (w - 1);
          a = rnd(); b = rnd(); m = '1;
          case (p)
            0: begin a = '1; b = rep(w, 64'd1); end          // R1 carry must not cross
            1: begin a = '0; b = rep(w, 64'd1); end          // R1 borrow must not cross
            3: m = '0;                                        // R6 nothing written
            4, 5: m = NS'($urandom());
            6: begin b = a; m = NS'($urandom()); end          // R4 equal operands
            7: begin a = rep(w, 64'd1 << (ew - 1)); b = rep(w, 64'd1); end // R4 overflow
            8: begin a = rep(w, 64'd1); b = rep(w, 64'd1 << (ew - 1)); end
            default: ;
          endcase
          step(1'b1, op, w, a, b, rnd(), m);
        end
      end
    end

    // R7: 8-bit width and undefined opcodes
    for (int op = 0; op <= 8; op++) step(1'b1, op, 0, rnd(), rnd(), rnd(), '1);
    for (int op = 9; op <= 15; op++) step(1'b1, op, 1 + (op % 3), rnd(), rnd(), rnd(), '1);

    // R8: bubbles interleaved with work
    for (int i = 0; i < 8; i++) step(i[0], 0, 1 + (i % 3), rnd(), rnd(), rnd(), NS'($urandom()));
    for (int i = 0; i < 3; i++) step(1'b0, 0, 1, '0, '0, '0, '0);

    // R9: reset with operations in flight
    step(1'b1, 0, 1, rnd(), rnd(), rnd(), '1);
    step(1'b1, 8, 3, rnd(), rnd(), rnd(), '1);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    check_clear("R9 mid-run reset");
    @(negedge clk);
    check_clear("R9 pipeline dropped");
    rst = 1'b0;
    flush_queues();
    for (int i = 0; i < 3; i++) step(1'b0, 0, 1, '0, '0, '0, '0);
    step(1'b1, 7, 2, rnd(), rnd(), rnd(), NS'($urandom()));
    for (int i = 0; i < 3; i++) step(1'b0, 0, 1, '0, '0, '0, '0);

    done = 1;
    summary();
    $finish;
  end
endmodule